// File: doc/BRIEF.md
# Serial Flash Interface Mode and Identification Decoder

This block sits on the device side of a serial flash bus. It oversamples chip select, the serial clock and four data lines with a fast system clock, and assembles each command's opcode. The opcode arrives one bit per rising serial clock edge in the single-line mode, or one nibble per edge in the four-line command mode. The block tracks which of these two mutually exclusive modes is active. It switches between them on dedicated opcodes, refuses four-line features while the quad-enable status bit is clear, and returns to the single-line mode on power-on reset or on a software reset opcode.

Accepted opcodes are presented to the rest of the device as a one-cycle strobe plus the opcode value. The three identification opcodes are answered here directly with fixed byte streams, shifted out on falling serial clock edges. The streams use one line in single-line mode and all four lines in four-line mode, and repeat while the host keeps clocking.

Top module: `sfid_front`

## Requirements
- R1: After reset, `qpi_mode_o` is 0, `cmd_stb_o` is 0 and `id_oe_o` is 4'b0000.
- R2: In single-line mode the opcode is taken from `io_i[0]`, most significant bit first, on 8 rising SCLK edges while `cs_n_i` is low. The block then gives one `cmd_stb_o` pulse with `cmd_op_o` equal to that opcode.
- R3: In four-line mode the opcode is taken from `io_i[3:0]` on 2 rising SCLK edges, high nibble first.
- R4: Opcode 8'h38 with `qe_i` = 1 sets `qpi_mode_o` only after `cs_n_i` rises; during the select it stays 0.
- R5: Opcode 8'h38 with `qe_i` = 0 produces no strobe and leaves `qpi_mode_o` unchanged.
- R6: The quad opcodes 8'h6B, 8'hEB, 8'hE7 and 8'h32 are strobed only when `qe_i` = 1; otherwise no strobe is produced.
- R7: Opcode 8'hFF or 8'h99 clears `qpi_mode_o` when `cs_n_i` rises.
- R8: After opcode 8'h9F, each falling SCLK edge drives the next bit of the repeating stream C8h, 60h, 16h, most significant bit first. In single-line mode the bit appears on `id_io_o[1]`, with `id_oe_o` = 4'b0010.
- R9: Opcode 8'h90 streams C8h, 15h repeating; opcode 8'hAB streams 15h repeating.
- R10: In four-line mode the identification stream is one nibble per falling SCLK edge on `id_io_o[3:0]`, high nibble first, with `id_oe_o` = 4'b1111.
- R11: Only the first complete opcode of a select is decoded; further bits in the same select produce no strobe and no mode change.
- R12: `id_oe_o` returns to 4'b0000 once `cs_n_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial bus |
| rst_n | input | 1 | Power-on reset, active low |
| cs_n_i | input | 1 | Chip select from the host, active low |
| sclk_i | input | 1 | Serial clock from the host |
| io_i | input | 4 | Data lines IO3..IO0 as driven by the host |
| qe_i | input | 1 | Quad-enable status bit |
| qpi_mode_o | output | 1 | 1 = four-line command mode active |
| cmd_stb_o | output | 1 | One-cycle pulse for each accepted opcode |
| cmd_op_o | output | 8 | Opcode of the most recent accepted command |
| id_io_o | output | 4 | Identification data toward the data lines |
| id_oe_o | output | 4 | Per-line output enable for `id_io_o` |

## Verification
The bench builds the block with its defaults: two synchronizer stages and the identification bytes C8h, 60h, 16h and 15h. With these values, every stream byte the bench compares is a concrete, distinct value, and bit-order or byte-order slips become visible. The serial clock half period spans eight system clocks, which leaves the synchronizer latency room to settle before each sample. Mode switching is driven through both opcode widths. It is checked with the quad-enable bit both set and clear, and before and after the chip select rises.

// File: rtl/sfid_pkg.sv
package sfid_pkg;

   localparam logic [7:0] OP_ENTER_QUAD = 8'h38;
   localparam logic [7:0] OP_EXIT_QUAD  = 8'hFF;
   localparam logic [7:0] OP_SOFT_RST   = 8'h99;
   localparam logic [7:0] OP_ID_JEDEC   = 8'h9F;
   localparam logic [7:0] OP_ID_MFRDEV  = 8'h90;
   localparam logic [7:0] OP_ID_DEV     = 8'hAB;

   typedef enum logic [1:0] {
      ID_NONE   = 2'd0,
      ID_JEDEC  = 2'd1,
      ID_MFRDEV = 2'd2,
      ID_DEV    = 2'd3
   } id_sel_e;

   function automatic logic needs_qe(input logic [7:0] op);
      return (op == 8'h6B) || (op == 8'hEB) || (op == 8'hE7) ||
             (op == 8'h32) || (op == OP_ENTER_QUAD);
   endfunction

   function automatic id_sel_e id_select(input logic [7:0] op);
      case (op)
         OP_ID_JEDEC:  return ID_JEDEC;
         OP_ID_MFRDEV: return ID_MFRDEV;
         OP_ID_DEV:    return ID_DEV;
         default:      return ID_NONE;
      endcase
   endfunction

   function automatic logic [1:0] id_last(input id_sel_e sel);
      case (sel)
         ID_JEDEC:  return 2'd2;
         ID_MFRDEV: return 2'd1;
         default:   return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/sfid_sync.sv
module sfid_sync #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n_i,
   input  logic       sclk_i,
   input  logic [3:0] io_i,
   output logic       cs_n_s,
   output logic [3:0] io_s,
   output logic       sclk_rise,
   output logic       sclk_fall,
   output logic       cs_rise
);
   localparam int         W     = 6;
   localparam logic [W-1:0] IDLE_V = 6'b10_0000;

   logic [W-1:0] raw_v;
   logic [W-1:0] syn_v;
   logic         sclk_s, sclk_p, cs_p;

   assign raw_v = {cs_n_i, sclk_i, io_i};

   generate
      if (STAGES == 0) begin : g_direct
         assign syn_v = raw_v;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) chain[k] <= IDLE_V;
            end else begin
               chain[0] <= raw_v;
               for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
            end
         end
         assign syn_v = chain[STAGES-1];
      end
   endgenerate

   assign cs_n_s = syn_v[5];
   assign sclk_s = syn_v[4];
   assign io_s   = syn_v[3:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p <= 1'b0;
         cs_p   <= 1'b1;
      end else begin
         sclk_p <= sclk_s;
         cs_p   <= cs_n_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_p & ~cs_n_s;
   assign sclk_fall = ~sclk_s & sclk_p & ~cs_n_s;
   assign cs_rise   = cs_n_s & ~cs_p;

endmodule

// File: rtl/sfid_opcode.sv
module sfid_opcode #(
   parameter int OP_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n_s,
   input  logic            sclk_rise,
   input  logic            qpi,
   input  logic [3:0]      io_s,
   output logic            op_stb,
   output logic [OP_W-1:0] op_code
);
   localparam int CNT_W = $clog2(OP_W + 1);

   logic [OP_W-1:0]  sh, sh_nxt;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic             done;

   always_comb begin
      if (qpi) begin
         sh_nxt  = {sh[OP_W-5:0], io_s};
         cnt_nxt = cnt + CNT_W'(4);
      end else begin
         sh_nxt  = {sh[OP_W-2:0], io_s[0]};
         cnt_nxt = cnt + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         cnt     <= '0;
         done    <= 1'b0;
         op_stb  <= 1'b0;
         op_code <= '0;
      end else begin
         op_stb <= 1'b0;
         if (cs_n_s) begin
            cnt  <= '0;
            done <= 1'b0;
         end else if (sclk_rise && !done) begin
            sh  <= sh_nxt;
            cnt <= cnt_nxt;
            if (cnt_nxt == CNT_W'(OP_W)) begin
               done    <= 1'b1;
               op_stb  <= 1'b1;
               op_code <= sh_nxt;
            end
         end
      end
   end

endmodule

// File: rtl/sfid_idgen.sv
module sfid_idgen
   import sfid_pkg::*;
#(
   parameter logic [7:0] MFR_ID   = 8'hC8,
   parameter logic [7:0] MEM_TYPE = 8'h60,
   parameter logic [7:0] CAPACITY = 8'h16,
   parameter logic [7:0] DEV_ID   = 8'h15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n_s,
   input  logic       sclk_fall,
   input  logic       qpi,
   input  logic       start,
   input  id_sel_e    sel,
   output logic [3:0] io_o,
   output logic [3:0] oe_o
);
   logic       active;
   id_sel_e    sel_q;
   logic [1:0] idx;
   logic [3:0] bcnt, bcnt_nxt;
   logic [7:0] cur, cur_sh;

   always_comb begin
      case (sel_q)
         ID_JEDEC:  cur = (idx == 2'd0) ? MFR_ID : (idx == 2'd1) ? MEM_TYPE : CAPACITY;
         ID_MFRDEV: cur = (idx == 2'd0) ? MFR_ID : DEV_ID;
         default:   cur = DEV_ID;
      endcase
      cur_sh   = cur << bcnt[2:0];
      bcnt_nxt = bcnt + (qpi ? 4'd4 : 4'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sel_q  <= ID_NONE;
         idx    <= '0;
         bcnt   <= '0;
         io_o   <= '0;
         oe_o   <= '0;
      end else if (cs_n_s) begin
         active <= 1'b0;
         io_o   <= '0;
         oe_o   <= '0;
      end else if (start) begin
         active <= 1'b1;
         sel_q  <= sel;
         idx    <= '0;
         bcnt   <= '0;
      end else if (sclk_fall && active) begin
         io_o <= qpi ? cur_sh[7:4] : {2'b00, cur_sh[7], 1'b0};
         oe_o <= qpi ? 4'b1111 : 4'b0010;
         if (bcnt_nxt == 4'd8) begin
            bcnt <= '0;
            idx  <= (idx == id_last(sel_q)) ? 2'd0 : idx + 2'd1;
         end else begin
            bcnt <= bcnt_nxt;
         end
      end
   end

endmodule

// File: rtl/sfid_front.sv
module sfid_front
   import sfid_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] MFR_ID      = 8'hC8,
   parameter logic [7:0] MEM_TYPE    = 8'h60,
   parameter logic [7:0] CAPACITY    = 8'h16,
   parameter logic [7:0] DEV_ID      = 8'h15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n_i,
   input  logic       sclk_i,
   input  logic [3:0] io_i,
   input  logic       qe_i,
   output logic       qpi_mode_o,
   output logic       cmd_stb_o,
   output logic [7:0] cmd_op_o,
   output logic [3:0] id_io_o,
   output logic [3:0] id_oe_o
);
   localparam int OP_W = 8;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("sfid_front: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic       cs_n_s, sclk_rise, sclk_fall, cs_rise;
   logic [3:0] io_s;
   logic       op_stb;
   logic [7:0] op_code;
   logic       accept;
   logic       pend_v, pend_q;

   sfid_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sclk_i(sclk_i), .io_i(io_i),
      .cs_n_s(cs_n_s), .io_s(io_s), .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall), .cs_rise(cs_rise)
   );

   sfid_opcode #(.OP_W(OP_W)) u_opc (
      .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_rise(sclk_rise),
      .qpi(qpi_mode_o), .io_s(io_s), .op_stb(op_stb), .op_code(op_code)
   );

   assign accept = qe_i || !needs_qe(op_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_stb_o  <= 1'b0;
         cmd_op_o   <= '0;
         qpi_mode_o <= 1'b0;
         pend_v     <= 1'b0;
         pend_q     <= 1'b0;
      end else begin
         cmd_stb_o <= op_stb && accept;
         if (op_stb && accept) cmd_op_o <= op_code;
         if (cs_rise) begin
            if (pend_v) qpi_mode_o <= pend_q;
            pend_v <= 1'b0;
         end else if (op_stb && accept) begin
            if (op_code == OP_ENTER_QUAD) begin
               pend_v <= 1'b1;
               pend_q <= 1'b1;
            end else if (op_code == OP_EXIT_QUAD || op_code == OP_SOFT_RST) begin
               pend_v <= 1'b1;
               pend_q <= 1'b0;
            end
         end
      end
   end

   sfid_idgen #(
      .MFR_ID(MFR_ID), .MEM_TYPE(MEM_TYPE), .CAPACITY(CAPACITY), .DEV_ID(DEV_ID)
   ) u_id (
      .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_fall(sclk_fall),
      .qpi(qpi_mode_o), .start(op_stb && (id_select(op_code) != ID_NONE)),
      .sel(id_select(op_code)), .io_o(id_io_o), .oe_o(id_oe_o)
   );

endmodule

// File: rtl/sfid_front_chk.sv
module sfid_front_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n_s,
   input logic       cs_rise,
   input logic       qe_i,
   input logic       qpi_mode_o,
   input logic       cmd_stb_o,
   input logic [7:0] cmd_op_o,
   input logic [3:0] id_oe_o
);
   // R4, R7: mode flips only right after the synchronized select rises
   p_mode_at_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(qpi_mode_o) |-> $past(cs_rise));

   // R5, R6: quad-gated opcodes never strobe with QE clear
   p_qe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb_o && (cmd_op_o == 8'h38 || cmd_op_o == 8'h6B || cmd_op_o == 8'hEB ||
                     cmd_op_o == 8'hE7 || cmd_op_o == 8'h32)) |-> $past(qe_i));

   // R11: at most one strobe per select, so never two in a row
   p_single_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb_o |=> !cmd_stb_o);

   // R12: drivers only while the select was low
   p_oe_in_select_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (id_oe_o != 4'b0000) |-> $past(!cs_n_s));

   // R8: single-line stream uses IO1 only
   p_oe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (id_oe_o == 4'b0010) |-> !qpi_mode_o);

   // R10: four-line stream drives every line, only in four-line mode
   p_oe_quad_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (id_oe_o != 4'b0000 && id_oe_o != 4'b0010) |-> (id_oe_o == 4'b1111 && qpi_mode_o));

endmodule

bind sfid_front sfid_front_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .cs_rise(cs_rise), .qe_i(qe_i),
   .qpi_mode_o(qpi_mode_o), .cmd_stb_o(cmd_stb_o), .cmd_op_o(cmd_op_o),
   .id_oe_o(id_oe_o)
);

// File: tb/sfid_front_test.sv
module sfid_front_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       qe = 1'b0;
   logic [3:0] io = 4'h0;
   logic       qpi_mode, cmd_stb;
   logic [7:0] cmd_op;
   logic [3:0] id_io, id_oe;

   int   n_run = 0, n_fail = 0;
   int   stb_cnt = 0;
   logic [7:0] stb_op = 8'h00;
   bit   model_qpi = 1'b0;
   bit   finished = 1'b0;

   sfid_front uut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .io_i(io),
      .qe_i(qe), .qpi_mode_o(qpi_mode), .cmd_stb_o(cmd_stb), .cmd_op_o(cmd_op),
      .id_io_o(id_io), .id_oe_o(id_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (rst_n && cmd_stb) begin
         stb_cnt = stb_cnt + 1;
         stb_op  = cmd_op;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic bit gated(input logic [7:0] op);
      return op == 8'h38 || op == 8'h6B || op == 8'hEB || op == 8'hE7 || op == 8'h32;
   endfunction

   function automatic logic [7:0] exp_id(input logic [7:0] op, input int i);
      logic [7:0] q[$];
      if (op == 8'h9F) q = '{8'hC8, 8'h60, 8'h16};
      else if (op == 8'h90) q = '{8'hC8, 8'h15};
      else q = '{8'h15};
      return q[i % q.size()];
   endfunction

   task automatic begin_sel();
      wait_clks(HALF);
      cs_n = 1'b0;
      stb_cnt = 0;
      wait_clks(HALF);
   endtask

   task automatic end_sel();
      wait_clks(HALF);
      cs_n = 1'b1;
      wait_clks(4*HALF);
   endtask

   task automatic clock_pulse();
      wait_clks(HALF);
      sclk = 1'b1;
      wait_clks(HALF);
      sclk = 1'b0;
   endtask

   task automatic send_op(input logic [7:0] b);
      if (model_qpi) begin
         for (int n = 0; n < 2; n++) begin
            io = (n == 0) ? b[7:4] : b[3:0];
            clock_pulse();
         end
      end else begin
         for (int n = 7; n >= 0; n--) begin
            io = {3'b000, b[n]};
            clock_pulse();
         end
      end
      io = 4'h0;
   endtask

   task automatic read_byte(output logic [7:0] v, output logic [3:0] oe);
      v = 8'h00;
      oe = 4'h0;
      for (int n = 0; n < (model_qpi ? 2 : 8); n++) begin
         wait_clks(HALF);
         v  = model_qpi ? {v[3:0], id_io} : {v[6:0], id_io[1]};
         oe = id_oe;
         sclk = 1'b1;
         wait_clks(HALF);
         sclk = 1'b0;
      end
   endtask

   task automatic do_cmd(input logic [7:0] op, input string req);
      bit acc;
      acc = !(gated(op) && !qe);
      begin_sel();
      send_op(op);
      chk({req, " mode held inside select"}, qpi_mode, model_qpi);
      end_sel();
      chk({req, " strobe count"}, stb_cnt, acc ? 1 : 0);
      if (acc) chk({req, " strobe opcode"}, stb_op, op);
      if (acc && op == 8'h38) model_qpi = 1'b1;
      if (acc && (op == 8'hFF || op == 8'h99)) model_qpi = 1'b0;
      chk({req, " mode after deselect"}, qpi_mode, model_qpi);
   endtask

   task automatic id_test(input logic [7:0] op, input int nbytes, input string req);
      logic [7:0] v;
      logic [3:0] oe;
      begin_sel();
      send_op(op);
      for (int i = 0; i < nbytes; i++) begin
         read_byte(v, oe);
         chk({req, " id byte"}, v, exp_id(op, i));
         chk({req, " id enable"}, oe, model_qpi ? 4'hF : 4'h2);
      end
      end_sel();
      chk({req, " id strobe"}, stb_op, op);
      chk("R12 enable released", id_oe, 4'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      wait_clks(5);
      chk("R1 mode at reset", qpi_mode, 0);
      chk("R1 enable at reset", id_oe, 0);
      chk("R1 strobe at reset", cmd_stb, 0);
      rst_n = 1'b1;
      wait_clks(5);

      // R2, R8, R9: single-line opcodes and identification streams
      id_test(8'h9F, 6, "R8");
      id_test(8'h90, 4, "R9");
      id_test(8'hAB, 2, "R9");
      do_cmd(8'h03, "R2");

      // R5, R6: gated opcodes with QE clear
      qe = 1'b0;
      do_cmd(8'h38, "R5");
      do_cmd(8'hEB, "R6");
      qe = 1'b1;
      do_cmd(8'h6B, "R6");
      do_cmd(8'h38, "R4");

      // R3, R10: four-line opcode reception and nibble stream
      do_cmd(8'hE7, "R3");
      id_test(8'h9F, 4, "R10");
      do_cmd(8'h32, "R6");

      // R11: trailing opcode in the same select is ignored
      begin_sel();
      send_op(8'h9F);
      send_op(8'hFF);
      end_sel();
      chk("R11 one strobe", stb_cnt, 1);
      chk("R11 first opcode kept", stb_op, 8'h9F);
      chk("R11 mode unchanged", qpi_mode, 1);

      // R7: both exit opcodes
      do_cmd(8'hFF, "R7");
      do_cmd(8'h38, "R4");
      do_cmd(8'h99, "R7");
      id_test(8'hAB, 1, "R9");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule